// File: doc/BRIEF.md
# Serial NOR Flash Program/Erase Sequencer

This block sits on the host side of a serial NOR flash. A client hands it one request: a page program, a 4 KB sector erase, a 32 KB or 64 KB block erase, or a whole-chip erase. The block then produces every SPI transaction the flash needs to carry out that request. It drives the serial lines itself in SPI mode 0, most significant bit first. It first unlocks the device for writing. It then sends the operation with its address and any payload. Finally it watches the device's busy flag until the flash reports that it is idle. The client learns of completion through a one-cycle done pulse, and of a refused request through a one-cycle err pulse.

Requests cross a ready/valid handshake that is open only while the engine is idle. A program request takes its payload from a separate byte stream, also under ready/valid, one byte for each byte transmitted. Program requests that are empty, or that would run past the end of a 256-byte page, are refused before any SPI activity starts.

The controller has ten states:

| State | What it does | Leaves when |
|---|---|---|
| S_IDLE | Waits for a request. | A legal request goes to S_WREN. A refused request stays in S_IDLE. |
| S_WREN | Sends the write-unlock byte. | The byte is done: to S_GAP1. |
| S_GAP1 | Holds select high. | GAP_CYC cycles have passed: to S_OPC. |
| S_OPC | Sends the operation byte. | The byte is done: to S_ADDR, or to S_GAP2 for chip erase. |
| S_ADDR | Sends three address bytes. | The third byte is done: to S_DATA for a program, otherwise to S_GAP2. |
| S_DATA | Sends the payload. | The last byte is done: to S_GAP2. |
| S_GAP2 | Holds select high. | GAP_CYC cycles have passed: to S_RDSR. |
| S_RDSR | Sends the status-read opcode. | The byte is done: to S_POLL. |
| S_POLL | Reads status bytes. | Busy reads 0: to S_DONE. While busy reads 1 it stays in S_POLL. |
| S_DONE | Select is high and done is pulsed. | Always: to S_IDLE. |

Top module: `nps_flash_sequencer`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done and err are 0.
- R2: Every accepted request begins with a chip-select frame that holds only the byte 0x06. Select returns high for at least GAP_CYC cycles before the operation frame starts.
- R3: The erase opcodes are sector 0x20, 32 KB block 0x52 and 64 KB block 0xD8. Each erase opcode is followed by three address bytes, high byte first. The low 12, 15 or 16 address bits are sent as zero for sector, 32 KB block and 64 KB block erase respectively.
- R4: Chip erase (req_op 4) sends a frame that holds only 0xC7, with no address.
- R5: A page program (req_op 0) sends 0x02, then the three address bytes unchanged, then exactly req_len bytes taken from wr_data in the order they were accepted. That whole sequence goes in one frame.
- R6: A request is refused when any of these holds: the op code is 5, 6 or 7; a program has req_len 0; a program has (req_addr[7:0] + req_len) > 256. A refused request produces one err pulse and no chip-select activity.
- R7: After the operation frame, the busy poll sends 0x05 once, then sends 0x00 bytes while reading status. Status bits are read MSB first and sampled on rising SCK. The poll keeps reading inside the same frame until a status byte with bit 0 = 0 has been received.
- R8: After the final status byte, chip select rises and done is high for exactly one cycle with spi_cs_n = 1. req_ready then returns to 1.
- R9: The serial port works in mode 0. SCK is low whenever chip select is high. MOSI does not change while SCK is high. Every frame contains a whole number of 8-bit bytes.
- R10: req_ready is 0 from the cycle after a request is accepted until the operation has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; a request can be taken |
| req_op | input | 3 | 0 program, 1 sector erase, 2 32 KB erase, 3 64 KB erase, 4 chip erase |
| req_addr | input | 24 | Byte address in the flash |
| req_len | input | 9 | Program byte count, 1 to 256 |
| wr_valid | input | 1 | Payload byte offered |
| wr_ready | output | 1 | Payload byte taken this cycle |
| wr_data | input | 8 | Payload byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with CLK_DIV = 2 and GAP_CYC = 3. With these values one byte takes 32 clocks, so a full 256-byte page program followed by a multi-byte busy poll completes in a few thousand cycles. This makes page-boundary programs, every erase alignment and long polls cheap enough to run back to back. The short gap still leaves a visible idle spell between frames, so the flash model can tell the frames apart.

// File: rtl/nps_pkg.sv
package nps_pkg;
    localparam int ADDR_W     = 24;
    localparam int PAGE_BYTES = 256;
    localparam int PG_BITS    = $clog2(PAGE_BYTES);
    localparam int LEN_W      = PG_BITS + 1;
    localparam int SEC_BYTES  = 4096;
    localparam int B32_BYTES  = 32768;
    localparam int B64_BYTES  = 65536;

    localparam logic [2:0] OP_PROG  = 3'd0;
    localparam logic [2:0] OP_SEC   = 3'd1;
    localparam logic [2:0] OP_B32   = 3'd2;
    localparam logic [2:0] OP_B64   = 3'd3;
    localparam logic [2:0] OP_CHIP  = 3'd4;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_PROG = 8'h02;
    localparam logic [7:0] CMD_SEC  = 8'h20;
    localparam logic [7:0] CMD_B32  = 8'h52;
    localparam logic [7:0] CMD_B64  = 8'hD8;
    localparam logic [7:0] CMD_CHIP = 8'hC7;
    localparam logic [7:0] CMD_RDSR = 8'h05;

    typedef enum logic [3:0] {
        S_IDLE, S_WREN, S_GAP1, S_OPC, S_ADDR,
        S_DATA, S_GAP2, S_RDSR, S_POLL, S_DONE
    } seq_state_t;
endpackage

// File: rtl/nps_byte_shifter.sv
module nps_byte_shifter #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic       rx_last
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    assign mosi = sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bitn    <= '0;
            sh      <= '0;
            sck     <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
            rx_last <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    sh   <= tx;
                    cnt  <= '0;
                    bitn <= '0;
                    sck  <= 1'b0;
                end
            end else if (cnt == CW'(DIV - 1)) begin
                cnt <= '0;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_last <= miso;
                end else begin
                    sck  <= 1'b0;
                    sh   <= {sh[6:0], 1'b0};
                    bitn <= bitn + 3'd1;
                    if (bitn == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/nps_req_check.sv
module nps_req_check
    import nps_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              ok,
    output logic [7:0]        opcode,
    output logic [ADDR_W-1:0] aligned,
    output logic              has_addr,
    output logic              has_data
);
    logic [LEN_W:0] reach;

    assign reach = (LEN_W + 1)'(addr[PG_BITS-1:0]) + (LEN_W + 1)'(len);

    always_comb begin
        ok       = 1'b1;
        opcode   = CMD_CHIP;
        aligned  = addr;
        has_addr = 1'b1;
        has_data = 1'b0;
        case (op)
            OP_PROG: begin
                opcode   = CMD_PROG;
                has_data = 1'b1;
                ok       = (len != '0) && (reach <= (LEN_W + 1)'(PAGE_BYTES));
            end
            OP_SEC: begin
                opcode  = CMD_SEC;
                aligned = addr & ~ADDR_W'(SEC_BYTES - 1);
            end
            OP_B32: begin
                opcode  = CMD_B32;
                aligned = addr & ~ADDR_W'(B32_BYTES - 1);
            end
            OP_B64: begin
                opcode  = CMD_B64;
                aligned = addr & ~ADDR_W'(B64_BYTES - 1);
            end
            OP_CHIP: begin
                aligned  = '0;
                has_addr = 1'b0;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/nps_flash_sequencer.sv
module nps_flash_sequencer
    import nps_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              done,
    output logic              err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    localparam int GCW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    seq_state_t        state, nxt;
    logic              ok, has_addr, has_data;
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] aligned;

    logic [7:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q, idx;
    logic              has_addr_q, has_data_q, fly, err_q;
    logic [GCW-1:0]    gcnt;

    logic              eng_start, eng_busy, eng_done, rx_last, tx_state;
    logic [7:0]        tx_byte;

    nps_req_check u_check (
        .op(req_op), .addr(req_addr), .len(req_len), .ok(ok),
        .opcode(opcode), .aligned(aligned),
        .has_addr(has_addr), .has_data(has_data)
    );

    nps_byte_shifter #(.DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(tx_byte),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
        .busy(eng_busy), .done(eng_done), .rx_last(rx_last)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid && ok) nxt = S_WREN;
            S_WREN: if (eng_done) nxt = S_GAP1;
            S_GAP1: if (gcnt == GCW'(GAP_CYC - 1)) nxt = S_OPC;
            S_OPC:  if (eng_done) nxt = has_addr_q ? S_ADDR : S_GAP2;
            S_ADDR: if (eng_done && idx == LEN_W'(2)) nxt = has_data_q ? S_DATA : S_GAP2;
            S_DATA: if (eng_done && idx == len_q - LEN_W'(1)) nxt = S_GAP2;
            S_GAP2: if (gcnt == GCW'(GAP_CYC - 1)) nxt = S_RDSR;
            S_RDSR: if (eng_done) nxt = S_POLL;
            S_POLL: if (eng_done && !rx_last) nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            opc_q      <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            has_addr_q <= 1'b0;
            has_data_q <= 1'b0;
            idx        <= '0;
            gcnt       <= '0;
            fly        <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state <= nxt;
            err_q <= (state == S_IDLE) && req_valid && !ok;
            if (state == S_IDLE && req_valid) begin
                opc_q      <= opcode;
                addr_q     <= aligned;
                len_q      <= req_len;
                has_addr_q <= has_addr;
                has_data_q <= has_data;
            end
            if (nxt != state) begin
                idx  <= '0;
                gcnt <= '0;
            end else begin
                gcnt <= gcnt + GCW'(1);
                if (eng_done) idx <= idx + LEN_W'(1);
            end
            if (eng_start)     fly <= 1'b1;
            else if (eng_done) fly <= 1'b0;
        end
    end

    always_comb begin
        req_ready = (state == S_IDLE);
        done      = (state == S_DONE);
        err       = err_q;
        tx_state  = 1'b0;
        tx_byte   = 8'h00;
        unique case (state)
            S_WREN: begin tx_state = 1'b1; tx_byte = CMD_WREN; end
            S_OPC:  begin tx_state = 1'b1; tx_byte = opc_q;    end
            S_ADDR: begin
                tx_state = 1'b1;
                tx_byte  = (idx == '0) ? addr_q[23:16] :
                           (idx == LEN_W'(1)) ? addr_q[15:8] : addr_q[7:0];
            end
            S_DATA: begin tx_state = 1'b1; tx_byte = wr_data;  end
            S_RDSR: begin tx_state = 1'b1; tx_byte = CMD_RDSR; end
            S_POLL: begin tx_state = 1'b1; tx_byte = 8'h00;    end
            default: ;
        endcase
        spi_cs_n  = !tx_state;
        wr_ready  = (state == S_DATA) && !fly && !eng_busy;
        eng_start = tx_state && !fly && !eng_busy && ((state != S_DATA) || wr_valid);
    end
endmodule

// File: rtl/nps_flash_sequencer_chk.sv
module nps_flash_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic done,
    input logic err,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi
);
    // R9: serial clock parked low whenever select is inactive
    a_r9_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R9: data line holds while the clock is high
    a_r9_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    // R8: completion pulse lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: completion only after select released
    a_r8_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);

    // R6: a refusal leaves the bus untouched and the engine idle
    a_r6_err_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (spi_cs_n && req_ready && !done));

    // R10: nothing on the bus while the engine offers ready
    a_r10_ready_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_cs_n);
endmodule

bind nps_flash_sequencer nps_flash_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .err(err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/nps_flash_sequencer_test.sv
`timescale 1ns/1ps
module nps_flash_sequencer_test;
    typedef struct { int val; string tag; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, wr_valid = 1'b0, spi_miso = 1'b0;
    logic [2:0] req_op = '0;
    logic [23:0] req_addr = '0;
    logic [8:0] req_len = '0;
    logic [7:0] wr_data = '0;
    logic req_ready, wr_ready, done, err, spi_sck, spi_cs_n, spi_mosi;

    int total = 0, bad = 0;
    int done_cnt = 0, err_cnt = 0, frames = 0;
    exp_t expq[$];

    // flash model state
    int bitcnt = 0, nbytes = 0, polls_left = 0;
    bit rd_mode = 0;
    logic [7:0] inb = '0, outsh = '0;

    always #2 clk = ~clk;

    nps_flash_sequencer #(.CLK_DIV(2), .GAP_CYC(3)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .done(done), .err(err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input int v, input string tag);
        exp_t e;
        e.val = v; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic take(input int v);
        exp_t e;
        if (expq.size() == 0) begin
            chk(0, "R2 unexpected bus item", v, -1);
        end else begin
            e = expq.pop_front();
            chk(v == e.val, e.tag, v, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (err) err_cnt++;
    end

    // monitor: flash side of the bus
    always @(negedge spi_cs_n) begin
        bitcnt = 0; nbytes = 0; rd_mode = 0;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        inb = {inb[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            take(int'(inb));
            if (nbytes == 0 && inb == 8'h05) rd_mode = 1;
            nbytes++;
        end
    end
    always @(negedge spi_sck) if (!spi_cs_n && rd_mode) begin
        if (bitcnt % 8 == 0) begin
            outsh = (polls_left > 0) ? 8'h03 : 8'h02;
            if (polls_left > 0) polls_left--;
        end else begin
            outsh = {outsh[6:0], 1'b0};
        end
        spi_miso = outsh[7];
    end
    always @(posedge spi_cs_n) if (rst_n) begin
        chk(bitcnt % 8 == 0, "R9 whole bytes", bitcnt, 0);
        take(256);
        frames++;
    end

    task automatic send_req(input logic [2:0] op, input logic [23:0] a, input logic [8:0] n);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = n;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] op, input logic [23:0] a, input int n, input int k);
        int base, start;
        logic [7:0] opc;
        logic [23:0] al;
        string t;
        base = done_cnt;
        opc = (op == 0) ? 8'h02 : (op == 1) ? 8'h20 : (op == 2) ? 8'h52 : (op == 3) ? 8'hD8 : 8'hC7;
        al = (op == 1) ? (a & ~24'hFFF) : (op == 2) ? (a & ~24'h7FFF) : (op == 3) ? (a & ~24'hFFFF) : a;
        t = (op == 0) ? "R5" : (op == 4) ? "R4" : "R3";
        push(8'h06, "R2 write-enable byte"); push(256, "R2 write-enable frame end");
        push(opc, t);
        if (op != 4) begin
            push(al[23:16], t); push(al[15:8], t); push(al[7:0], t);
        end
        for (int i = 0; i < n; i++) push((a[7:0] + i * 7 + 3) & 8'hFF, "R5 payload");
        push(256, t);
        push(8'h05, "R7 status opcode");
        for (int i = 0; i <= k; i++) push(8'h00, "R7 poll filler");
        push(256, "R7 poll frame end");
        polls_left = k;
        send_req(op, a, 9'(n));
        chk(req_ready == 1'b0, "R10 ready low when busy", req_ready, 0);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1; wr_data = 8'((a[7:0] + i * 7 + 3) & 8'hFF);
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        start = 0;
        while (done_cnt == base && start < 40000) begin @(negedge clk); start++; end
        chk(spi_cs_n == 1'b1, "R8 select high at done", spi_cs_n, 1);
        repeat (3) @(negedge clk);
        chk(done_cnt == base + 1, "R8 one done pulse", done_cnt - base, 1);
        chk(req_ready == 1'b1, "R8 ready back", req_ready, 1);
        chk(expq.size() == 0, "R7 all bus items seen", expq.size(), 0);
        expq.delete();
    endtask

    task automatic bad_req(input logic [2:0] op, input logic [23:0] a, input logic [8:0] n);
        int e0, f0, d0;
        e0 = err_cnt; f0 = frames; d0 = done_cnt;
        send_req(op, a, n);
        repeat (20) @(negedge clk);
        chk(err_cnt == e0 + 1, "R6 err pulse", err_cnt - e0, 1);
        chk(frames == f0, "R6 no frame", frames - f0, 0);
        chk(done_cnt == d0, "R6 no done", done_cnt - d0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R8 watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(err == 1'b0, "R1 err", err, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_op(3'd1, 24'h123456, 0, 2);   // R3 sector
        do_op(3'd2, 24'hABCDEF, 0, 0);   // R3 32 KB
        do_op(3'd3, 24'h3FFFFF, 0, 1);   // R3 64 KB
        do_op(3'd4, 24'h55AA55, 0, 3);   // R4 chip
        do_op(3'd0, 24'h001010, 4, 1);   // R5 short program
        do_op(3'd0, 24'h020080, 128, 2); // R5 runs exactly to page end
        do_op(3'd0, 24'h7F0000, 256, 0); // R5 full page
        bad_req(3'd0, 24'h000010, 9'd0);   // R6 empty
        bad_req(3'd0, 24'h0000F0, 9'd17);  // R6 one past page end
        bad_req(3'd5, 24'h000000, 9'd1);   // R6 undefined op
        bad_req(3'd7, 24'h000000, 9'd1);   // R6 undefined op
        do_op(3'd1, 24'h000FFF, 0, 5);   // R7 long poll after refusals

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule